// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 16-bit DAC that takes its samples over a serial line. It has three asynchronous pins: a bit clock, a data line and a load strobe. Each pin passes through a synchronizer into a faster system clock, and edges are detected in that clock domain. On each falling bit-clock edge the current data bit enters a shift register, most significant bit first. On each falling edge of the load strobe, the sixteen most recently received bits are copied to the parallel DAC register. That register drives the twos-complement sample code and an offset-binary copy of it.

A timing monitor works in the same domain. It measures the data setup time before each falling bit-clock edge, the data hold time after it, and the high and low widths of the load strobe, all in system-clock cycles. Any measurement below its threshold parameter sets a sticky error flag.

Top module: `serdac_front`

## Requirements
- R1: After reset, the sample code is 0 (midscale), the offset-binary output is 16'h8000 and the error flag is 0. The shift register is also cleared, so bits shifted in afterwards are preceded by zeros.
- R2: Bits are captured on falling bit-clock edges, most significant bit first. After the 16 bits b15..b0 are sent and the strobe falls, the sample code equals {b15..b0}.
- R3: When more than 16 bits arrive between strobe falls, only the last 16 are kept. Example: sending the 20 bits of 20'hABCDE gives code 16'hBCDE.
- R4: The sample code changes only after a falling strobe edge. Shifted bits and a rising or high strobe leave the output unchanged.
- R5: A strobe fall does not clear the shift register. After word 16'h1234, sending the 8 bits 8'h56 and a strobe fall gives 16'h3456.
- R6: The offset-binary output equals (code + 16'h8000) mod 2^16, which is the code with its MSB inverted.
- R7: If data changes fewer than SETUP_MIN system cycles before a falling bit-clock edge, the error flag is set.
- R8: If data changes 1 to HOLD_MIN-1 system cycles after a falling bit-clock edge, the error flag is set.
- R9: A strobe high time shorter than LE_HI_MIN system cycles sets the error flag.
- R10: A strobe low time shorter than LE_LO_MIN system cycles sets the error flag.
- R11: The error flag stays set until reset. Traffic that meets every threshold never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| load_i | input | 1 | Load strobe; its falling edge updates the DAC register |
| code_o | output | W | Twos-complement sample code |
| obin_o | output | W | Offset-binary version of the sample code |
| terr_o | output | 1 | Sticky timing-violation flag |

## Verification
Whole words are applied as walking-one and walking-zero patterns, as full-scale and midscale corners and as a pseudo-random series. These show up a wrong bit order, a stuck or swapped bit, and a faulty sign conversion. Short and over-long bursts check that only the newest 16 bits survive and that a load does not clear the shift register. Before each strobe fall, and while the strobe is high, the output is compared with the previous word to catch an early update. For each timing rule, one stimulus is placed just below its threshold, and compliant traffic confirms that the flag stays clear.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int RULE_SETUP = 0;
  localparam int RULE_HOLD  = 1;
  localparam int RULE_LEHI  = 2;
  localparam int RULE_LELO  = 3;
  localparam int NRULES     = 4;

  // cnt holds (span - 1); true when span falls below the minimum
  function automatic logic span_short(input int unsigned cnt, input int unsigned min_span);
    return (cnt + 1) < min_span;
  endfunction
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [STAGES:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_i};
  end

  assign cur_o  = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/serdac_shift.sv
module serdac_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         load_en,
  output logic [W-1:0] shreg_o,
  output logic [W-1:0] dac_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_o <= '0;
      dac_o   <= '0;
    end else begin
      if (shift_en) shreg_o <= {shreg_o[W-2:0], din};
      if (load_en)  dac_o   <= shreg_o;
    end
  end
endmodule

// File: rtl/serdac_timing.sv
module serdac_timing
  import serdac_pkg::*;
#(
  parameter int CW        = 4,
  parameter int SETUP_MIN = 3,
  parameter int HOLD_MIN  = 3,
  parameter int LE_HI_MIN = 4,
  parameter int LE_LO_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic              data_chg,
  input  logic              le_rise,
  input  logic              le_fall,
  output logic [NRULES-1:0] viol_o,
  output logic              err_o
);
  localparam int NCNT = 3;

  logic [NCNT-1:0] clr;
  logic [CW-1:0]   cnt [NCNT];

  assign clr[0] = data_chg;
  assign clr[1] = bit_fall;
  assign clr[2] = le_rise | le_fall;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CW-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         c_q <= '1;
      else if (clr[g])    c_q <= '0;
      else if (c_q != '1) c_q <= c_q + 1'b1;
    end
    assign cnt[g] = c_q;
  end

  assign viol_o[RULE_SETUP] = bit_fall & (data_chg | span_short(32'(cnt[0]), SETUP_MIN));
  assign viol_o[RULE_HOLD]  = data_chg & ~bit_fall & span_short(32'(cnt[1]), HOLD_MIN);
  assign viol_o[RULE_LEHI]  = le_fall & span_short(32'(cnt[2]), LE_HI_MIN);
  assign viol_o[RULE_LELO]  = le_rise & span_short(32'(cnt[2]), LE_LO_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_o | (|viol_o);
  end
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC      = 2,
  parameter int SETUP_MIN = 3,
  parameter int HOLD_MIN  = 3,
  parameter int LE_HI_MIN = 4,
  parameter int LE_LO_MIN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_i,
  input  logic         sdata_i,
  input  logic         load_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] obin_o,
  output logic         terr_o
);
  localparam int MAXA   = (SETUP_MIN > HOLD_MIN) ? SETUP_MIN : HOLD_MIN;
  localparam int MAXB   = (LE_HI_MIN > LE_LO_MIN) ? LE_HI_MIN : LE_LO_MIN;
  localparam int MAXMIN = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW     = $clog2(MAXMIN + 1) + 1;
  localparam int IB = 0, ID = 1, IL = 2;

  function automatic logic [W-1:0] to_offset_bin(input logic [W-1:0] c);
    return {~c[W-1], c[W-2:0]};
  endfunction

  logic [2:0]        cur, prev;
  logic              bit_fall, data_chg, le_rise, le_fall, din;
  logic [W-1:0]      shreg;
  logic [NRULES-1:0] viol;

  serdac_sync #(.N(3), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({load_i, sdata_i, bclk_i}),
    .cur_o(cur), .prev_o(prev)
  );

  assign bit_fall = prev[IB] & ~cur[IB];
  assign data_chg = prev[ID] ^ cur[ID];
  assign le_rise  = ~prev[IL] & cur[IL];
  assign le_fall  = prev[IL] & ~cur[IL];
  assign din      = cur[ID];

  serdac_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(bit_fall), .din(din), .load_en(le_fall),
    .shreg_o(shreg), .dac_o(code_o)
  );

  serdac_timing #(
    .CW(CW), .SETUP_MIN(SETUP_MIN), .HOLD_MIN(HOLD_MIN),
    .LE_HI_MIN(LE_HI_MIN), .LE_LO_MIN(LE_LO_MIN)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .bit_fall(bit_fall), .data_chg(data_chg),
    .le_rise(le_rise), .le_fall(le_fall),
    .viol_o(viol), .err_o(terr_o)
  );

  assign obin_o = to_offset_bin(code_o);
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_fall,
  input logic         le_fall,
  input logic         din,
  input logic [W-1:0] shreg,
  input logic [W-1:0] code,
  input logic [W-1:0] obin,
  input logic [3:0]   viol,
  input logic         err
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  a_r1_reset_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code == '0 && shreg == '0 && !err));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fall |=> (shreg[0] == $past(din) && shreg[W-1:1] == $past(shreg[W-2:0])));

  a_r4_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !le_fall |=> $stable(code));

  a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    le_fall |=> code == $past(shreg));

  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    obin == W'(code + HALF));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(|viol));
endmodule

bind serdac_front serdac_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .le_fall(le_fall),
  .din(din), .shreg(shreg), .code(code_o), .obin(obin_o),
  .viol(viol), .err(terr_o)
);

// File: tb/test_serdac_front.sv
module test_serdac_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, sdata = 1'b0, load = 1'b0;
  logic [15:0] code, obin;
  logic terr;

  int nvec = 0, nerr = 0;
  logic [15:0] model_sh = '0, exp_code = '0;

  always #2 clk = ~clk;

  serdac_front i_serdac_front (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .sdata_i(sdata), .load_i(load),
    .code_o(code), .obin_o(obin), .terr_o(terr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0; load = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    model_sh = '0; exp_code = '0;
  endtask

  task automatic send_bit(input logic b);
    bclk = 1'b1; sdata = b;
    tick(4);
    bclk = 1'b0;
    tick(4);
    model_sh = {model_sh[14:0], b};
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  // strobe high then low, checking no update before the fall (R4)
  task automatic do_load(input string rq);
    chk("R4 before strobe", code, exp_code);
    load = 1'b1;
    tick(6);
    chk("R4 strobe high", code, exp_code);
    load = 1'b0;
    tick(6);
    exp_code = model_sh;
    chk(rq, code, exp_code);
    chk("R6 offset", obin, exp_code + 16'h8000);
  endtask

  task automatic apply_word(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
    do_load("R2 word");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    do_reset();
    chk("R1 code", code, 16'h0000);
    chk("R1 obin", obin, 16'h8000);
    chk("R1 flag", {15'h0, terr}, 16'h0);

    // R1: cleared shift register shows up as leading zeros
    send_bits(32'hA5, 8);
    do_load("R1 cleared shreg");

    apply_word(16'h0000);
    apply_word(16'hFFFF);
    apply_word(16'h8000);
    apply_word(16'h7FFF);
    apply_word(16'h0001);
    for (int i = 0; i < 16; i++) apply_word(16'h1 << i);
    for (int i = 0; i < 16; i++) apply_word(~(16'h1 << i));
    lf = 16'hACE1;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply_word(lf);
    end

    // R3: overlong burst keeps the newest 16 bits
    send_bits(32'hABCDE, 20);
    do_load("R3 overlong");
    chk("R3 value", code, 16'hBCDE);

    // R5: short burst after a load mixes with old bits
    apply_word(16'h1234);
    send_bits(32'h56, 8);
    do_load("R5 partial");
    chk("R5 value", code, 16'h3456);

    chk("R11 clean traffic flag", {15'h0, terr}, 16'h0);

    // R7: data changes one cycle before the falling bit clock
    do_reset();
    bclk = 1'b1; sdata = 1'b0; tick(4);
    sdata = 1'b1; tick(1);
    bclk = 1'b0; tick(6);
    chk("R7 setup flag", {15'h0, terr}, 16'h1);
    send_bits(32'h0F0F, 16);
    load = 1'b1; tick(6); load = 1'b0; tick(6);
    chk("R11 sticky flag", {15'h0, terr}, 16'h1);

    // R8: data changes one cycle after the falling bit clock
    do_reset();
    chk("R1 flag after reset", {15'h0, terr}, 16'h0);
    bclk = 1'b1; sdata = 1'b0; tick(4);
    bclk = 1'b0; tick(1);
    sdata = 1'b1; tick(6);
    chk("R8 hold flag", {15'h0, terr}, 16'h1);

    // R9: short strobe high
    do_reset();
    load = 1'b1; tick(2);
    load = 1'b0; tick(6);
    chk("R9 high width flag", {15'h0, terr}, 16'h1);

    // R10: short strobe low between two legal high pulses
    do_reset();
    load = 1'b1; tick(5);
    load = 1'b0; tick(6);
    chk("R10 legal pulse flag", {15'h0, terr}, 16'h0);
    load = 1'b1; tick(5);
    load = 1'b0; tick(2);
    load = 1'b1; tick(5);
    load = 1'b0; tick(6);
    chk("R10 low width flag", {15'h0, terr}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule